// File: doc/BRIEF.md
# I2C Line Glitch Filter

This block cleans the SCL and SDA inputs of an I2C controller before the protocol engine sees them. Each raw line first passes through a two-stage synchronizer. It then passes through a per-line pulse rejector. A level change reaches the filtered output only if it persists for longer than a programmable number of internal clock cycles. Shorter pulses are discarded. Both lines use one shared length setting, but each line has its own counter, so the two lines never interact.

The length setting lives in a small configuration register reached through a plain write strobe and a read bus.
- The stored value occupies the low byte of a 32-bit word, and the upper bits read as zero.
- A write of zero is raised to one, because one cycle is the shortest legal filter.
- Writes are accepted only while the interface enable input is low. A write that arrives while the enable input is high is dropped without notice.
- After reset the setting is seven cycles, and both filtered lines rest high, which is the idle level of the bus.

Top module: `i2c_glitch_filter`

## Requirements
- R1: After reset both filtered outputs are 1 and the length register reads 7.
- R2: The read bus returns the stored length in bits 7:0 and zero in bits 31:8. An accepted write stores bits 7:0 of the write data and ignores bits 31:8.
- R3: An accepted write whose bits 7:0 are zero stores the value 1.
- R4: A write while the enable input is 1 leaves the stored length unchanged.
- R5: A raw pulse held for N clock cycles or fewer, where N is the stored length, causes no change on the filtered output.
- R6: A raw level held for more than N cycles appears on the filtered output. The output changes at the (N+3)th rising edge, counting as the first edge the one that first samples the new raw level.
- R7: Both lines use the same stored length and are filtered independently. A pulse on one line never changes or delays the other filtered line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_raw | input | 1 | Unfiltered clock line from the pad |
| sda_raw | input | 1 | Unfiltered data line from the pad |
| if_enable | input | 1 | Interface enable; while 1 the length register is locked |
| cfg_wr | input | 1 | Length register write strobe |
| cfg_wdata | input | 32 | Length register write data |
| cfg_rdata | output | 32 | Length register read data |
| scl_filt | output | 1 | Filtered clock line |
| sda_filt | output | 1 | Filtered data line |

## Verification
A counter that fails to restart when the line returns to its filtered level shows up in one of two ways. Either a rejected pulse leaks through, or a real edge appears earlier than N+3 cycles. The scoreboard compares every output transition against a predicted edge cycle, so an error is caught on the first disagreement. A bad length register shows at once on the read bus, and it also moves every subsequent edge by the size of the error. Because each line's transitions are predicted separately, any crosstalk between the two counters appears as an unexpected edge.

// File: rtl/i2c_glitch_filter_pkg.sv
// Package: shared widths and reset constants for the I2C glitch filter.
// Assumes: a two-line bus (clock and data) and an 8-bit length field.
package i2c_glitch_filter_pkg;
    localparam int LEN_W       = 8;
    localparam int DATA_W      = 32;
    localparam int SYNC_STAGES = 2;
    localparam int NUM_LINES   = 2;
    localparam logic [LEN_W-1:0] LEN_RESET = 8'd7;
    localparam logic [LEN_W-1:0] LEN_MIN   = 8'd1;

    typedef enum int {
        LINE_SCL = 0,
        LINE_SDA = 1
    } line_idx_e;
endpackage

// File: rtl/i2c_gf_sync.sv
// Module: i2c_gf_sync
// Multi-stage synchronizer for one asynchronous pad input.
// Assumes: the input idles high, so every stage resets to 1.
module i2c_gf_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    // Shift the pad level through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '1;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], din};
        end
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/i2c_gf_len_reg.sv
// Module: i2c_gf_len_reg
// Holds the filter length. Writes below the minimum are raised to it,
// and writes are dropped while the interface is enabled.
// Assumes: a single-cycle write strobe; read data is combinational.
module i2c_gf_len_reg
    import i2c_glitch_filter_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              if_enable,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [LEN_W-1:0]  len
);
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] wr_val;
    logic             wr_ok;

    // Clamp the incoming byte to the legal minimum.
    always_comb begin
        wr_val = wdata[LEN_W-1:0];
        if (wr_val < LEN_MIN) begin
            wr_val = LEN_MIN;
        end
    end

    assign wr_ok = wr && !if_enable;

    // Store an accepted write; otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q <= LEN_RESET;
        end else if (wr_ok) begin
            len_q <= wr_val;
        end
    end

    assign len   = len_q;
    assign rdata = {{(DATA_W-LEN_W){1'b0}}, len_q};
endmodule

// File: rtl/i2c_gf_line.sv
// Module: i2c_gf_line
// Pulse rejector for one synchronized line.
// Assumes: len is at least 1. The output idles high after reset.
module i2c_gf_line #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             din,
    input  logic [CNT_W-1:0] len,
    output logic             dout
);
    logic             filt_q;
    logic [CNT_W-1:0] cnt_q;

    // Count cycles of disagreement; flip once the count exceeds the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            filt_q <= 1'b1;
            cnt_q  <= '0;
        end else if (din == filt_q) begin
            cnt_q <= '0;
        end else if (cnt_q >= len) begin
            filt_q <= din;
            cnt_q  <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign dout = filt_q;
endmodule

// File: rtl/i2c_glitch_filter.sv
// Module: i2c_glitch_filter (top)
// Synchronizes and deglitches SCL and SDA using one programmable length.
// Assumes: raw inputs are asynchronous. The length register is written
// only through cfg_wr and is locked while if_enable is 1.
module i2c_glitch_filter
    import i2c_glitch_filter_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_raw,
    input  logic              sda_raw,
    input  logic              if_enable,
    input  logic              cfg_wr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    output logic              scl_filt,
    output logic              sda_filt
);
    logic [LEN_W-1:0]     len;
    logic [NUM_LINES-1:0] line_raw;
    logic [NUM_LINES-1:0] line_sync;
    logic [NUM_LINES-1:0] line_filt;

    i2c_gf_len_reg u_len (
        .clk      (clk),
        .rst_n    (rst_n),
        .if_enable(if_enable),
        .wr       (cfg_wr),
        .wdata    (cfg_wdata),
        .rdata    (cfg_rdata),
        .len      (len)
    );

    assign line_raw[LINE_SCL] = scl_raw;
    assign line_raw[LINE_SDA] = sda_raw;

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        i2c_gf_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (line_raw[g]),
            .dout (line_sync[g])
        );
        i2c_gf_line #(.CNT_W(LEN_W)) u_filt (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (line_sync[g]),
            .len  (len),
            .dout (line_filt[g])
        );
    end

    assign scl_filt = line_filt[LINE_SCL];
    assign sda_filt = line_filt[LINE_SDA];
endmodule

// File: rtl/i2c_glitch_filter_chk.sv
// Module: i2c_glitch_filter_chk
// Property checker bound to the top module.
module i2c_glitch_filter_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        if_enable,
    input logic        cfg_wr,
    input logic [31:0] cfg_wdata,
    input logic [31:0] cfg_rdata,
    input logic [1:0]  line_sync,
    input logic [1:0]  line_filt
);
    // R2: upper read bits are always zero
    p_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[31:8] == 24'd0);

    // R2: an accepted nonzero write is read back
    p_write_takes_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !if_enable && cfg_wdata[7:0] != 8'd0)
        |=> cfg_rdata[7:0] == $past(cfg_wdata[7:0]));

    // R3: a zero write reads back as one
    p_clamp_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !if_enable && cfg_wdata[7:0] == 8'd0)
        |=> cfg_rdata[7:0] == 8'd1);

    // R4: the register is frozen while enabled
    p_lock_r4: assert property (@(posedge clk) disable iff (!rst_n)
        if_enable |=> $stable(cfg_rdata));

    // R5: the clock line changes only after its input held the new level
    p_scl_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(line_filt[0])
        |-> ($past(line_sync[0]) == line_filt[0]
             && $past(line_sync[0], 2) == line_filt[0]));

    // R7: the data line obeys the same rule on its own input
    p_sda_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(line_filt[1])
        |-> ($past(line_sync[1]) == line_filt[1]
             && $past(line_sync[1], 2) == line_filt[1]));
endmodule

bind i2c_glitch_filter i2c_glitch_filter_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .if_enable(if_enable),
    .cfg_wr   (cfg_wr),
    .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata),
    .line_sync(line_sync),
    .line_filt(line_filt)
);

// File: tb/i2c_glitch_filter_tb.sv
// Scoreboard bench: drivers predict filtered edges; a monitor matches them.
module i2c_glitch_filter_tb;
    typedef struct {
        int line;
        bit lvl;
        int cyc;
    } edge_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_raw = 1'b1;
    logic        sda_raw = 1'b1;
    logic        if_enable = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        scl_filt, sda_filt;

    int    checks = 0;
    int    fails = 0;
    int    cyc = 0;
    int    cur_len = 7;
    bit    done = 1'b0;
    bit    mon_on = 1'b0;
    edge_t exp_q[$];

    i2c_glitch_filter u_dut (
        .clk(clk), .rst_n(rst_n), .scl_raw(scl_raw), .sda_raw(sda_raw),
        .if_enable(if_enable), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .scl_filt(scl_filt), .sda_filt(sda_filt)
    );

    always #4 clk = ~clk;  // 125 MHz

    always @(posedge clk) cyc = cyc + 1;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Monitor: every filtered transition must match the oldest expected edge.
    initial begin
        logic prev_s = 1'b1;
        logic prev_d = 1'b1;
        forever begin
            @(negedge clk);
            if (mon_on) begin
                for (int l = 0; l < 2; l++) begin
                    logic now_v;
                    logic prev_v;
                    now_v  = (l == 0) ? scl_filt : sda_filt;
                    prev_v = (l == 0) ? prev_s : prev_d;
                    if (now_v != prev_v) begin
                        if (exp_q.size() == 0) begin
                            check("R5 unexpected edge line", l, -1);
                        end else begin
                            edge_t e;
                            e = exp_q.pop_front();
                            check("R7 edge line", l, e.line);
                            check("R6 edge level", int'(now_v), int'(e.lvl));
                            check("R6 edge cycle", cyc, e.cyc);
                        end
                    end
                end
            end
            prev_s = scl_filt;
            prev_d = sda_filt;
        end
    end

    task automatic reg_write(input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1;
        cfg_wdata = d;
        if (!if_enable) cur_len = (d[7:0] == 8'd0) ? 1 : int'(d[7:0]);
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic set_line(input int l, input logic v);
        if (l == 0) scl_raw = v; else sda_raw = v;
    endtask

    // Driver: low pulse of w cycles on line l; predict filtered edges.
    task automatic pulse(input int l, input int w);
        int k;
        @(negedge clk);
        k = cyc;
        set_line(l, 1'b0);
        if (w > cur_len) begin
            exp_q.push_back('{l, 1'b0, k + cur_len + 3});
            exp_q.push_back('{l, 1'b1, k + w + cur_len + 3});
        end
        repeat (w) @(negedge clk);
        set_line(l, 1'b1);
        repeat (cur_len + 8) @(negedge clk);
    endtask

    task automatic triple(input int l);
        if (cur_len > 1) pulse(l, cur_len - 1);
        pulse(l, cur_len);
        pulse(l, cur_len + 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        mon_on = 1'b1;
        check("R1 scl reset", int'(scl_filt), 1);
        check("R1 sda reset", int'(sda_filt), 1);
        check("R1 len reset", int'(cfg_rdata), 7);

        triple(0);             // N=7 on SCL
        triple(1);             // N=7 on SDA

        reg_write(32'h0);
        check("R3 zero clamps", int'(cfg_rdata), 1);
        triple(0);             // N=1

        reg_write(32'hABCD_FF03);
        check("R2 upper bits dropped", int'(cfg_rdata), 3);
        triple(1);

        // R7: long SCL pulse overlapping a rejected SDA pulse (N=3)
        begin
            int k;
            @(negedge clk);
            k = cyc;
            scl_raw = 1'b0;
            exp_q.push_back('{0, 1'b0, k + 6});
            exp_q.push_back('{0, 1'b1, k + 12});
            @(negedge clk);
            sda_raw = 1'b0;
            repeat (3) @(negedge clk);
            sda_raw = 1'b1;
            repeat (2) @(negedge clk);
            scl_raw = 1'b1;
            repeat (12) @(negedge clk);
        end

        reg_write(32'hFF);
        check("R2 max length", int'(cfg_rdata), 255);
        triple(0);             // N=255

        if_enable = 1'b1;
        reg_write(32'h5);
        check("R4 locked write", int'(cfg_rdata), 255);
        reg_write(32'h0);
        check("R4 locked zero", int'(cfg_rdata), 255);
        pulse(1, 255);         // R4: still filtered at 255
        if_enable = 1'b0;

        reg_write(32'h2);
        check("R2 write 2", int'(cfg_rdata), 2);
        triple(1);

        repeat (5) @(negedge clk);
        check("R6 all edges seen", exp_q.size(), 0);
        check("R1 idle scl", int'(scl_filt), 1);
        check("R1 idle sda", int'(sda_filt), 1);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule